// File: doc/BRIEF.md
# Triplex Block Voter with Nonanswer Detection

The voter watches three redundant processing channels. During a voting frame each channel fills its own buffer of result words through a private write port. Every write also marks that channel's status bit as fresh. When the frame boundary arrives, the block takes a snapshot of the three status bits and clears them. It then walks the three buffers one word per clock and compares every channel pair across the whole block.

A block counts as agreeing only when all of its words match. If exactly one answering channel disagrees, that channel is flagged and the majority block is published, so the error is masked. If a channel wrote nothing during the frame, it is treated as a nonanswer whatever its buffer holds. It is left out of the vote and flagged. When no two answering channels agree, a transfer-to-backup request is raised and the previously published block stays in place.

The published block is read by word address. The fault vector and the backup request hold from one verdict until the next. A one-cycle valid pulse marks each new verdict.

Top module: `tmr_block_voter`

## Requirements
- R1: A write on channel c stores `ch_wr_data[16c+15:16c]` at word `ch_wr_addr[4c+3:4c]` when `ch_wr_en[c]` is high. From the next cycle on, `ch_fresh[c]` reads 1.
- R2: A frame tick taken by an idle voter clears all three `ch_fresh` bits in the cycle after the clock edge that samples it. The bits that were set before that edge become the answer mask for the frame.
- R3: `vote_valid` rises in the cycle after the 17th rising edge that follows the edge that took the frame tick. That is 16 compare cycles plus one decision cycle. The pulse lasts exactly one cycle.
- R4: When all three channels answer and their blocks are identical, the block is published, `channel_fault` is 000 and `backup_req` is 0.
- R5: When all three answer and one channel differs from the other two in any word, bit c of `channel_fault` (for that channel only) is set, `backup_req` is 0, and the agreeing pair's block is published.
- R6: When all three answer and no two blocks are identical, `backup_req` is 1, `channel_fault` is 000, and the published block keeps its previous contents.
- R7: Two channels presenting identical wrong blocks form a valid majority. Their block is published and the third channel is flagged.
- R8: A channel whose status bit was 0 at the frame tick is excluded from the vote and flagged in `channel_fault`. If the two answering channels agree, their block is published with `backup_req` 0.
- R9: With fewer than two answering channels, or two answering channels that disagree, `backup_req` is 1, every silent channel is flagged, and the published block is kept. This holds even when a silent channel's stale buffer matches one of the answering channels.
- R10: A frame tick that arrives while a comparison is running is held. A new comparison starts on the edge that ends the current one, so the next `vote_valid` comes exactly 17 cycles after the first.
- R11: After reset, `channel_fault` is 000, `backup_req` and `vote_valid` are 0, `ch_fresh` is 000, and every published word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_wr_en | input | 3 | Per-channel write strobe, bit c for channel c |
| ch_wr_addr | input | 12 | Per-channel word address, 4 bits per channel, channel c at bits 4c+3:4c |
| ch_wr_data | input | 48 | Per-channel write data, 16 bits per channel, channel c at bits 16c+15:16c |
| frame_tick | input | 1 | Frame boundary; starts a comparison |
| rd_addr | input | 4 | Word address into the published block |
| rd_data | output | 16 | Published word at rd_addr (combinational) |
| ch_fresh | output | 3 | Per-channel status: 1 when the channel wrote since the last tick taken |
| channel_fault | output | 3 | Channels flagged by the latest verdict |
| backup_req | output | 1 | Latest verdict found no majority |
| vote_valid | output | 1 | One-cycle pulse when a verdict is registered |

## Verification
A stuck or skipped word counter changes the latency of `vote_valid` or lets a corrupted word escape comparison. A disagreement planted at every word of every channel exposes either fault in the very frame it happens. A wrong answer mask shows up in the first frame that has a silent channel: the faulty verdict flags the wrong channel or publishes data where backup was due. A held tick that was lost or repeated moves the second pulse away from 17 cycles. Every published word is read back after each verdict, so a stage-to-publish fault appears at the next read-back.

// File: rtl/tmrv_pkg.sv
package tmrv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [2:0] fault;
    logic       backup;
  } verdict_t;

  // Block-level verdict from the answer mask and pairwise block equality.
  function automatic verdict_t f_decide(logic [2:0] ans, logic eq01,
                                        logic eq02, logic eq12);
    verdict_t v;
    v.fault  = ~ans;
    v.backup = 1'b1;
    case (ans)
      3'b111: begin
        if (eq01 && eq02) begin
          v.fault  = 3'b000;
          v.backup = 1'b0;
        end else if (eq01) begin
          v.fault  = 3'b100;
          v.backup = 1'b0;
        end else if (eq02) begin
          v.fault  = 3'b010;
          v.backup = 1'b0;
        end else if (eq12) begin
          v.fault  = 3'b001;
          v.backup = 1'b0;
        end
      end
      3'b011:  if (eq01) v.backup = 1'b0;
      3'b101:  if (eq02) v.backup = 1'b0;
      3'b110:  if (eq12) v.backup = 1'b0;
      default: v.backup = 1'b1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tmrv_chan_buf.sv
module tmrv_chan_buf #(
  parameter int DW    = 16,
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic          fresh
);

  logic [WORDS-1:0][DW-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  // A write in the same cycle as a take belongs to the next frame.
  always_ff @(posedge clk) begin
    if (!rst_n)     fresh <= 1'b0;
    else if (wr_en) fresh <= 1'b1;
    else if (take)  fresh <= 1'b0;
  end

  assign rd_word = mem_q[rd_idx];

  p_fresh_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> fresh);

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_addr) |=> rd_word == $past(wr_data) || $past(rd_idx) != rd_idx);

  p_take_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> !fresh);

endmodule

// File: rtl/tmrv_seq.sv
module tmrv_seq
  import tmrv_pkg::*;
#(
  parameter int DW    = 16,
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic [2:0]    fresh,
  input  logic [DW-1:0] w0,
  input  logic [DW-1:0] w1,
  input  logic [DW-1:0] w2,
  output logic          take,
  output logic          busy,
  output logic [AW-1:0] idx,
  output logic          done,
  output logic [2:0]    ans,
  output logic          eq01,
  output logic          eq02,
  output logic          eq12
);

  seq_state_t st_q;
  logic       pend_q;
  logic       ne01_q, ne02_q, ne12_q;
  logic       start_go;
  logic       last_word;

  assign busy      = (st_q == ST_BUSY);
  assign done      = (st_q == ST_DONE);
  assign last_word = busy && (idx == AW'(WORDS - 1));
  assign start_go  = ((st_q == ST_IDLE) && frame_tick) ||
                     (done && (pend_q || frame_tick));
  assign take      = start_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx    <= '0;
      pend_q <= 1'b0;
      ans    <= 3'b000;
      ne01_q <= 1'b0;
      ne02_q <= 1'b0;
      ne12_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_go) st_q <= ST_BUSY;
        ST_BUSY: if (last_word) st_q <= ST_DONE;
        ST_DONE: st_q <= start_go ? ST_BUSY : ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
      if (start_go) begin
        idx    <= '0;
        ans    <= fresh;
        pend_q <= 1'b0;
        ne01_q <= 1'b0;
        ne02_q <= 1'b0;
        ne12_q <= 1'b0;
      end else begin
        if (frame_tick && st_q != ST_IDLE) pend_q <= 1'b1;
        if (busy) begin
          idx    <= AW'(idx + 1'b1);
          ne01_q <= ne01_q | (w0 != w1);
          ne02_q <= ne02_q | (w0 != w2);
          ne12_q <= ne12_q | (w1 != w2);
        end
      end
    end
  end

  assign eq01 = !ne01_q;
  assign eq02 = !ne02_q;
  assign eq12 = !ne12_q;

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_word) |=> busy && idx == AW'($past(idx) + 1'b1));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_tick_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && busy) |=> pend_q);

  p_mask_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> ans == $past(fresh) && busy);

endmodule

// File: rtl/tmrv_result.sv
module tmrv_result
  import tmrv_pkg::*;
#(
  parameter int DW    = 16,
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] w0,
  input  logic [DW-1:0] w1,
  input  logic [DW-1:0] w2,
  input  logic [2:0]    ans,
  input  logic          eq01,
  input  logic          eq02,
  input  logic          eq12,
  input  logic          done,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    channel_fault,
  output logic          backup_req,
  output logic          vote_valid
);

  // Word-level pick among answering channels; equals the block majority
  // whenever a block majority exists.
  function automatic logic [DW-1:0] f_pick(logic [2:0] m, logic [DW-1:0] a,
                                           logic [DW-1:0] b, logic [DW-1:0] c);
    if (m[0] && m[1] && a == b)      return a;
    else if (m[0] && m[2] && a == c) return a;
    else if (m[1] && m[2] && b == c) return b;
    else                             return a;
  endfunction

  logic [WORDS-1:0][DW-1:0] stage_q;
  logic [WORDS-1:0][DW-1:0] pub_q;
  verdict_t                 verdict;
  logic                     commit;

  assign verdict = f_decide(ans, eq01, eq02, eq12);
  assign commit  = done && !verdict.backup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (busy) begin
      stage_q[idx] <= f_pick(ans, w0, w1, w2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pub_q         <= '0;
      channel_fault <= 3'b000;
      backup_req    <= 1'b0;
      vote_valid    <= 1'b0;
    end else begin
      vote_valid <= done;
      if (done) begin
        channel_fault <= verdict.fault;
        backup_req    <= verdict.backup;
      end
      if (commit) pub_q <= stage_q;
    end
  end

  assign rd_data = pub_q[rd_addr];

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vote_valid |=> !vote_valid);

  p_hold_on_backup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && verdict.backup) |=> $stable(pub_q) && backup_req);

  p_single_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_valid && !backup_req) |-> $onehot0(channel_fault));

  p_all_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ans == 3'b000) |=> backup_req && channel_fault == 3'b111);

  p_verdict_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(channel_fault) && $stable(backup_req));

endmodule

// File: rtl/tmr_block_voter.sv
module tmr_block_voter #(
  parameter int DW    = 16,
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      ch_wr_en,
  input  logic [3*AW-1:0] ch_wr_addr,
  input  logic [3*DW-1:0] ch_wr_data,
  input  logic            frame_tick,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [2:0]      ch_fresh,
  output logic [2:0]      channel_fault,
  output logic            backup_req,
  output logic            vote_valid
);

  logic [2:0][DW-1:0] cur_word;
  logic               take;
  logic               busy;
  logic               done;
  logic [AW-1:0]      idx;
  logic [2:0]         ans;
  logic               eq01, eq02, eq12;

  for (genvar g = 0; g < 3; g++) begin : g_chan
    tmrv_chan_buf #(.DW(DW), .WORDS(WORDS)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ch_wr_en[g]),
      .wr_addr (ch_wr_addr[g*AW +: AW]),
      .wr_data (ch_wr_data[g*DW +: DW]),
      .take    (take),
      .rd_idx  (idx),
      .rd_word (cur_word[g]),
      .fresh   (ch_fresh[g])
    );
  end

  tmrv_seq #(.DW(DW), .WORDS(WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .fresh      (ch_fresh),
    .w0         (cur_word[0]),
    .w1         (cur_word[1]),
    .w2         (cur_word[2]),
    .take       (take),
    .busy       (busy),
    .idx        (idx),
    .done       (done),
    .ans        (ans),
    .eq01       (eq01),
    .eq02       (eq02),
    .eq12       (eq12)
  );

  tmrv_result #(.DW(DW), .WORDS(WORDS)) u_res (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .idx           (idx),
    .w0            (cur_word[0]),
    .w1            (cur_word[1]),
    .w2            (cur_word[2]),
    .ans           (ans),
    .eq01          (eq01),
    .eq02          (eq02),
    .eq12          (eq12),
    .done          (done),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .channel_fault (channel_fault),
    .backup_req    (backup_req),
    .vote_valid    (vote_valid)
  );

  p_fresh_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ch_wr_en == 3'b000) |=> ch_fresh == 3'b000);

  p_valid_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> vote_valid);

endmodule

// File: tb/sim_tmr_block_voter.sv
module sim_tmr_block_voter;
  localparam int DW = 16;
  localparam int WORDS = 16;
  localparam int AW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      ch_wr_en = '0;
  logic [3*AW-1:0] ch_wr_addr = '0;
  logic [3*DW-1:0] ch_wr_data = '0;
  logic            frame_tick = 1'b0;
  logic [AW-1:0]   rd_addr = '0;
  logic [DW-1:0]   rd_data;
  logic [2:0]      ch_fresh;
  logic [2:0]      channel_fault;
  logic            backup_req;
  logic            vote_valid;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pub_seed = -1;

  always #2.5 clk = ~clk;

  tmr_block_voter #(.DW(DW), .WORDS(WORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_wr_en(ch_wr_en), .ch_wr_addr(ch_wr_addr),
    .ch_wr_data(ch_wr_data), .frame_tick(frame_tick), .rd_addr(rd_addr),
    .rd_data(rd_data), .ch_fresh(ch_fresh), .channel_fault(channel_fault),
    .backup_req(backup_req), .vote_valid(vote_valid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] pat(int s, int w);
    if (s < 0) return 16'h0000;
    return 16'(s * 32'h1357 + w * 32'h0F0F) ^ 16'(w << 8) ^ 16'(s << 12);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_frame(int s0, int s1, int s2, logic [2:0] en, int bad_ch, int bad_w);
    int sd[3];
    sd[0] = s0; sd[1] = s1; sd[2] = s2;
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      ch_wr_en = en;
      for (int c = 0; c < 3; c++) begin
        ch_wr_addr[c*AW +: AW] = AW'(w);
        ch_wr_data[c*DW +: DW] = pat(sd[c], w) ^
          ((c == bad_ch && w == bad_w) ? 16'h8001 : 16'h0000);
      end
    end
    @(negedge clk);
    ch_wr_en = '0;
  endtask

  task automatic chk_block(string tag);
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      rd_addr = AW'(w);
      #1;
      chk(tag, rd_data, pat(pub_seed, w));
    end
  endtask

  // Tick, then count negedges until the verdict pulse (18 = 17 edges after the tick edge).
  task automatic run_frame(output int lat);
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    chk("R2 fresh cleared after tick", ch_fresh, 3'b000);
    lat = 1;
    while (!vote_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic frame_check(string tag, logic [2:0] efault, logic eback, int eseed);
    int lat;
    run_frame(lat);
    chk({tag, " R3 latency"}, lat, 18);
    chk({tag, " fault"}, channel_fault, efault);
    chk({tag, " backup"}, backup_req, eback);
    @(negedge clk);
    chk({tag, " R3 pulse width"}, vote_valid, 1'b0);
    if (!eback) pub_seed = eseed;
    chk_block({tag, " block"});
  endtask

  initial begin
    int lat, lat2;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 fault", channel_fault, 3'b000);
    chk("R11 backup", backup_req, 1'b0);
    chk("R11 valid", vote_valid, 1'b0);
    chk("R11 fresh", ch_fresh, 3'b000);
    rd_addr = 4'd15; #1;
    chk("R11 word15", rd_data, 16'h0000);
    rst_n = 1'b1;

    // R1 / R4: all agree
    wr_frame(1, 1, 1, 3'b111, -1, 0);
    chk("R1 fresh set", ch_fresh, 3'b111);
    frame_check("R4 agree", 3'b000, 1'b0, 1);

    // R5: single corrupted word at every position of every channel
    for (int c = 0; c < 3; c++) begin
      for (int w = 0; w < WORDS; w++) begin
        wr_frame(10 + c*16 + w, 10 + c*16 + w, 10 + c*16 + w, 3'b111, c, w);
        frame_check("R5 single", 3'(1 << c), 1'b0, 10 + c*16 + w);
      end
    end

    // R7: two identical wrong blocks win
    wr_frame(3, 3, 4, 3'b111, -1, 0);
    frame_check("R7 common mode", 3'b100, 1'b0, 3);

    // R6: all differ, block kept
    wr_frame(5, 6, 7, 3'b111, -1, 0);
    frame_check("R6 all differ", 3'b000, 1'b1, 0);

    // R8: each channel silent in turn, others agree
    for (int c = 0; c < 3; c++) begin
      wr_frame(40 + c, 40 + c, 40 + c, 3'(3'b111 & ~(1 << c)), -1, 0);
      chk("R1 fresh partial", ch_fresh, 3'(3'b111 & ~(1 << c)));
      frame_check("R8 silent", 3'(1 << c), 1'b0, 40 + c);
    end

    // R9: stale silent data matching one answering channel must not form a majority
    wr_frame(50, 50, 50, 3'b111, -1, 0);
    frame_check("R9 setup", 3'b000, 1'b0, 50);
    wr_frame(50, 51, 0, 3'b011, -1, 0);
    frame_check("R9 stale ignored", 3'b100, 1'b1, 0);
    wr_frame(0, 52, 0, 3'b010, -1, 0);
    frame_check("R9 one answer", 3'b101, 1'b1, 0);
    frame_check("R9 none answer", 3'b111, 1'b1, 0);

    // R10: tick during comparison is held
    wr_frame(60, 60, 60, 3'b111, -1, 0);
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    repeat (5) @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    lat = 0;
    while (!vote_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 first valid", vote_valid, 1'b1);
    chk("R10 first fault", channel_fault, 3'b000);
    chk("R10 first backup", backup_req, 1'b0);
    pub_seed = 60;
    lat2 = 0;
    do begin
      @(negedge clk);
      lat2++;
    end while (!vote_valid && lat2 < 60);
    chk("R10 held tick spacing", lat2, 17);
    chk("R10 second fault", channel_fault, 3'b111);
    chk("R10 second backup", backup_req, 1'b1);
    chk_block("R10 block kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule